// File: doc/BRIEF.md
# Truncated Shift-Add Tree with Carry Bias

This block sums a set of Q two's-complement partial words in one pass and returns a fixed-width P-bit result. Word number q is worth 2^-q of word 0, so each word sits q columns further to the right. The whole weighted sum is formed by a fully unrolled adder tree. There is no serial shift-and-accumulate loop.

Only the P most significant columns are actually added. The columns below them are dropped, and the carry they would have produced is replaced by a small integer bias that is added at the result's least significant bit. The bias is built from two parts. The first part counts the ones in the dropped column directly below the kept LSB, and that count is used exactly. The second part is a closed-form estimate for the deeper dropped columns. The estimate depends only on Q, because each deeper bit is taken to be 1 with probability one half.

Typical use is inside the datapath of a distributed-arithmetic transform, where many shifted words must be combined every cycle and the full-precision sum is too costly. A parameter places one output register after the tree. Without it, the block is purely combinational.

Top module: `trunc_comp_adder`

## Requirements
- R1: Word q (bits [q*P +: P] of `words_i`, q = 0..Q-1) adds to the result as that word arithmetically shifted right by q bits. The output equals the sum of these shifted words plus the bias.
- R2: When Q is less than 4, the bias equals c/2 rounded to nearest with ties upward. Here c is the number of ones among bit q-1 of word q, for q = 1..Q-1.
- R3: When Q mod 4 is 0 or 1 (Q at least 4, k = Q div 4), the bias is (k-1) + round_half_up(c/2 + 0.5).
- R4: When Q mod 4 is 2 or 3 (k = Q div 4), the bias is k + round_half_up(c/2). With P=12 and Q=6 this gives a bias between 1 and 4, and all-zero words therefore yield 1.
- R5: Only bit q-1 of word q, for q of 1 or more, enters the exact column count. Word 0 has no dropped bits, and lower bits of a word affect the result only through the fixed estimate.
- R6: The sum wraps modulo 2^P. No saturation is applied.
- R7: With P=12 and Q=6, the output differs from the exact weighted sum by at most 2 LSB. The exact sum is taken at full precision and then rounded to nearest, and the difference is taken modulo 2^P.
- R8: With the output register enabled, `sum_o` is 0 while reset is asserted. After reset it shows the result for the words present at the previous rising clock edge. With the register disabled, `sum_o` follows `words_i` within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| words_i | input | Q*P | Packed partial words; word q at bits [q*P +: P] |
| sum_o | output | P | Fixed-width compensated sum |

## Verification
A wrong column count or a wrong bias constant shows up at once as an offset of a few LSB in `sum_o`. In the registered build it appears one clock after the words that trigger it. A fault in the tree, such as a wrong shift of one word, shows up as a large error whenever that word is nonzero. The same fault causes the full-precision error bound to be broken. The bench compares every cycle against a behavioural model. It also checks the bound against both the exact rounded sum and the plainly truncated sum, so a bias that is right on average but wrong for some column counts is still caught.

// File: rtl/tca_pkg.sv
package tca_pkg;

    typedef enum logic [1:0] {
        MODE_ROUND_ONLY,
        MODE_HALF_LIFT,
        MODE_OFFSET
    } bias_mode_e;

    function automatic bias_mode_e mode_of(input int q);
        if (q < 4)
            return MODE_ROUND_ONLY;
        else if ((q % 4) < 2)
            return MODE_HALF_LIFT;
        else
            return MODE_OFFSET;
    endfunction

    // constant part of the bias
    function automatic int base_of(input int q);
        case (mode_of(q))
            MODE_HALF_LIFT: return (q / 4) - 1;
            MODE_OFFSET:    return q / 4;
            default:        return 0;
        endcase
    endfunction

    // added to the column count before halving (rounding / half lift)
    function automatic int add_of(input int q);
        return (mode_of(q) == MODE_HALF_LIFT) ? 2 : 1;
    endfunction

    function automatic int bias_lo(input int q);
        return base_of(q) + (add_of(q) / 2);
    endfunction

    function automatic int bias_hi(input int q);
        int top;
        top = (q > 0) ? q - 1 : 0;
        return base_of(q) + ((top + add_of(q)) / 2);
    endfunction

endpackage

// File: rtl/tca_column_count.sv
module tca_column_count #(
    parameter int P  = 12,
    parameter int Q  = 6,
    parameter int CW = $clog2(Q + 1)
) (
    input  logic [Q*P-1:0] words_i,
    output logic [CW-1:0]  cnt_o
);

    // ones in the first dropped column: bit q-1 of word q
    always_comb begin
        cnt_o = '0;
        for (int q = 1; q < Q; q++) begin
            cnt_o = cnt_o + CW'(words_i[q*P + q - 1]);
        end
    end

endmodule

// File: rtl/tca_bias_gen.sv
module tca_bias_gen #(
    parameter int P  = 12,
    parameter int Q  = 6,
    parameter int CW = $clog2(Q + 1)
) (
    input  logic [CW-1:0] cnt_i,
    output logic [P-1:0]  bias_o
);

    localparam int BASE = tca_pkg::base_of(Q);
    localparam int ADD  = tca_pkg::add_of(Q);

    logic [P-1:0] lifted;

    always_comb begin
        lifted = P'(cnt_i) + P'(ADD);
        bias_o = P'(BASE) + (lifted >> 1);
    end

endmodule

// File: rtl/tca_tree.sv
module tca_tree #(
    parameter int P = 12,
    parameter int Q = 6
) (
    input  logic [Q*P-1:0] words_i,
    output logic [P-1:0]   sum_o
);

    localparam int LV = $clog2(Q);
    localparam int NP = 1 << LV;

    // heap-ordered nodes: leaves at NP..2*NP-1, root at 1
    logic [P-1:0] node [1:2*NP-1];

    for (genvar i = 0; i < NP; i++) begin : g_leaf
        if (i < Q) begin : g_word
            assign node[NP+i] = P'($signed(words_i[i*P +: P]) >>> i);
        end else begin : g_pad
            assign node[NP+i] = '0;
        end
    end

    for (genvar n = 1; n < NP; n++) begin : g_add
        assign node[n] = node[2*n] + node[2*n+1];
    end

    assign sum_o = node[1];

endmodule

// File: rtl/trunc_comp_adder.sv
module trunc_comp_adder #(
    parameter int P       = 12,
    parameter int Q       = 6,
    parameter bit OUT_REG = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [Q*P-1:0] words_i,
    output logic [P-1:0]   sum_o
);

    localparam int CW = $clog2(Q + 1);

    typedef struct packed {
        logic [P-1:0] sum;
    } res_t;

    logic [CW-1:0] cnt_w;
    logic [P-1:0]  bias_w;
    logic [P-1:0]  tree_w;
    res_t          res_d;
    res_t          res_q;

    tca_column_count #(.P(P), .Q(Q), .CW(CW)) u_count (
        .words_i (words_i),
        .cnt_o   (cnt_w)
    );

    tca_bias_gen #(.P(P), .Q(Q), .CW(CW)) u_bias (
        .cnt_i  (cnt_w),
        .bias_o (bias_w)
    );

    tca_tree #(.P(P), .Q(Q)) u_tree (
        .words_i (words_i),
        .sum_o   (tree_w)
    );

    always_comb begin
        res_d     = res_q;
        res_d.sum = tree_w + bias_w;
    end

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                res_q <= '0;
            else
                res_q <= res_d;
        end
        assign sum_o = res_q.sum;
    end else begin : g_comb
        assign res_q = '0;
        assign sum_o = res_d.sum;
    end

endmodule

// File: rtl/trunc_comp_adder_chk.sv
module trunc_comp_adder_chk #(
    parameter int P       = 12,
    parameter int Q       = 6,
    parameter bit OUT_REG = 1'b1,
    parameter int CW      = $clog2(Q + 1)
) (
    input logic           clk,
    input logic           rst_n,
    input logic [Q*P-1:0] words_i,
    input logic [P-1:0]   sum_o,
    input logic [P-1:0]   sum_d,
    input logic [P-1:0]   bias,
    input logic [CW-1:0]  cnt
);

    localparam int LO  = tca_pkg::bias_lo(Q);
    localparam int HI  = tca_pkg::bias_hi(Q);
    localparam int MAXC = (Q > 0) ? Q - 1 : 0;

    // the column count can never exceed the number of shifted words
    p_count_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) <= MAXC);

    // bias stays inside the window of its case rule
    p_bias_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(bias) >= LO) && (int'(bias) <= HI));

    if (OUT_REG) begin : g_reg_chk
        p_reset_clear_r8: assert property (@(posedge clk)
            !rst_n |=> sum_o == '0);

        p_reg_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> sum_o == $past(sum_d));
    end else begin : g_comb_chk
        p_hold_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
            $stable(words_i) |-> $stable(sum_o));
    end

endmodule

bind trunc_comp_adder trunc_comp_adder_chk #(
    .P(P), .Q(Q), .OUT_REG(OUT_REG)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .words_i (words_i),
    .sum_o   (sum_o),
    .sum_d   (res_d.sum),
    .bias    (bias_w),
    .cnt     (cnt_w)
);

// File: tb/trunc_comp_adder_bench.sv
`timescale 1ns/1ps
module trunc_comp_adder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [71:0] in6 = '0;
    logic [29:0] in3 = '0;
    logic [95:0] in8 = '0;
    logic [11:0] out6;
    logic [9:0]  out3;
    logic [11:0] out8;

    int n_chk = 0;
    int n_err = 0;
    int w6 [8];
    int w3 [8];
    int w8 [8];
    int exp6, exp3, exp8;
    bit have_exp = 1'b0;

    always #4 clk = ~clk;

    trunc_comp_adder #(.P(12), .Q(6), .OUT_REG(1'b1)) u_trunc_comp_adder (
        .clk(clk), .rst_n(rst_n), .words_i(in6), .sum_o(out6));
    trunc_comp_adder #(.P(10), .Q(3), .OUT_REG(1'b0)) u_trunc_comp_adder_q3 (
        .clk(clk), .rst_n(rst_n), .words_i(in3), .sum_o(out3));
    trunc_comp_adder #(.P(12), .Q(8), .OUT_REG(1'b1)) u_trunc_comp_adder_q8 (
        .clk(clk), .rst_n(rst_n), .words_i(in8), .sum_o(out8));

    function automatic int model(input int w[8], input int p, input int q);
        int s, c, k, b;
        s = 0; c = 0;
        for (int i = 0; i < q; i++) begin
            s += w[i] >>> i;
            if (i > 0) c += (w[i] >> (i - 1)) & 1;
        end
        k = q / 4;
        if (q < 4)            b = (c + 1) / 2;
        else if ((q % 4) < 2) b = (k - 1) + (c + 2) / 2;
        else                  b = k + (c + 1) / 2;
        return (s + b) & ((1 << p) - 1);
    endfunction

    function automatic int wrap12(input int v);
        int r;
        r = v & 4095;
        return (r >= 2048) ? r - 4096 : r;
    endfunction

    task automatic chk(input string tag, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic report();
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    function automatic int rnd_word(input int p);
        return int'($urandom % (1 << p)) - (1 << (p - 1));
    endfunction

    // apply at a falling edge, check comb/registered timing, then results
    task automatic run_vec(input string tag);
        int ex, r, d, dt;
        int old6;
        old6 = exp6;
        for (int i = 0; i < 8; i++) begin
            if (i < 6) in6[i*12 +: 12] = w6[i][11:0];
            if (i < 3) in3[i*10 +: 10] = w3[i][9:0];
            in8[i*12 +: 12] = w8[i][11:0];
        end
        exp6 = model(w6, 12, 6);
        exp3 = model(w3, 10, 3);
        exp8 = model(w8, 12, 8);
        #1;
        chk({tag, " R8 comb same cycle"}, int'(out3), exp3);
        if (have_exp) chk({tag, " R8 reg holds old"}, int'(out6), old6);
        @(negedge clk);
        have_exp = 1'b1;
        chk({tag, " R4 q6"}, int'(out6), exp6);
        chk({tag, " R2 q3"}, int'(out3), exp3);
        chk({tag, " R3 q8"}, int'(out8), exp8);
        // R7: error against exact rounded sum (scaled by 32)
        ex = 0; dt = 0;
        for (int i = 0; i < 6; i++) begin
            ex += w6[i] * (1 << (5 - i));
            dt += w6[i] >>> i;
        end
        r = (ex + 16) >>> 5;
        d = wrap12(int'(out6) - r);
        chk({tag, " R7 |err|<=2"}, (d >= -2 && d <= 2) ? 1 : 0, 1);
        d = wrap12(int'(out6) - dt);
        chk({tag, " R4 bias 1..4 over truncated"}, (d >= 1 && d <= 4) ? 1 : 0, 1);
    endtask

    task automatic fill(input int v6, input int v3, input int v8);
        for (int i = 0; i < 8; i++) begin
            w6[i] = v6; w3[i] = v3; w8[i] = v8;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        report();
    end

    initial begin
        fill(0, 0, 0);
        repeat (3) @(negedge clk);
        chk("R8 reset q6", int'(out6), 0);
        chk("R8 reset q8", int'(out8), 0);
        rst_n = 1'b1;

        fill(0, 0, 0);
        run_vec("zeros");
        chk("R4 zero words give bias 1", int'(out6), 1);

        fill(0, 0, 0);
        w6[1] = 1; w3[1] = 1; w8[1] = 1;
        run_vec("R5 single column bit");
        chk("R5 q6 one column bit", int'(out6), 2);

        fill(0, 0, 0);
        w6[3] = 3; w3[2] = 1; w8[5] = 15;
        run_vec("R5 deep bits only");
        chk("R5 q6 bits below column ignored", int'(out6), 1);

        fill(-1, -1, -1);
        run_vec("R1 all ones");
        chk("R1 q6 all ones", int'(out6), 12'hFFE);

        fill(-2048, -512, -2048);
        run_vec("R6 most negative");
        chk("R6 q6 wrap", int'(out6), 65);

        fill(2047, 511, 2047);
        run_vec("R6 most positive");

        for (int n = 0; n < 300; n++) begin
            for (int i = 0; i < 8; i++) begin
                if (n % 3 == 0) begin
                    w6[i] = int'($urandom % 8) - 4;
                    w3[i] = int'($urandom % 8) - 4;
                    w8[i] = int'($urandom % 512) - 256;
                end else begin
                    w6[i] = rnd_word(12);
                    w3[i] = rnd_word(10);
                    w8[i] = rnd_word(12);
                end
            end
            run_vec("R1 random");
        end

        rst_n = 1'b0;
        #1;
        chk("R8 async reset q6", int'(out6), 0);
        report();
    end

endmodule